// File: doc/BRIEF.md
# External Bus Cycle Stretch Controller

This block sits between a microcontroller core and its external expansion bus. It holds an 8-bit option register, decodes each core access as on-chip or off-chip, and produces the external E clock, the external bus enable and the data-bus drive enable. When the stretch option is on, an off-chip access that falls in the slow-device window gets one extra E cycle. During that cycle the E clock is held low and the core is told to wait. The internal phase counter and the free-running tick counter are never held, so timers and serial logic see no disturbance.

The core offers each access on a valid/ready channel: `acc_valid` with `acc_addr` and `acc_rnw`. The core must hold all three stable until it samples `acc_ready` high at a rising edge. The block accepts a new access only in the last phase of an E cycle. `acc_ready` is the only back-pressure, and it is high for exactly one clock at the end of the access. Other pins are plain levels or strobes. The block also shapes the load-instruction strobe. It pulls low for one clock, and in expanded modes it can follow that with an active high drive for a quarter of an E cycle.

Mode encoding on `mode`: 0 single-chip, 1 expanded, 2 bootstrap, 3 special test. The block treats modes 1 and 3 as expanded-like.

Top module: `xbus_stretch_ctl`

## Requirements
- R1: The mode present during reset sets the reset value of the register. `opt_q` reads 8'h10 if that mode was special test (3), and 8'h00 otherwise.
- R2: A `reg_wr` with `reg_addr` = 6'h38 updates option bits 7,6,5,3,2 from `reg_wdata`. Bits 1:0 always read 0. Writes to other offsets change nothing.
- R3: The visibility bit (bit 4) takes only the first write at 6'h38 made outside special test mode, and later writes leave it unchanged until reset. Writes to the other bits still take effect. In special test mode every write updates the visibility bit.
- R4: An access is off-chip only in modes 1 or 3, and only when the address lies outside the RAM (16'h0000–16'h03FF) and outside the register page (16'h1000–16'h103F). `ext_en` is high for the whole of an off-chip access and never during an on-chip one.
- R5: An off-chip access is stretched when option bit 5 is set and bit 15 of the address is 0 (if `rom_low`=1) or 1 (if `rom_low`=0). On-chip accesses are never stretched.
- R6: A plain access lasts EPER clocks and a stretched one lasts 2*EPER clocks. During the first EPER clocks of a stretched access `core_wait` is high and `e_clk` is low.
- R7: `itick` advances by exactly one on every clock after reset, whether or not an access is stretched.
- R8: `data_oe` is high during the final E cycle of an off-chip write. It is also high during an on-chip read when option bit 4 is set in mode 1 or 3. It is low in all other cases.
- R9: One clock after `fetch_req`, `fetch_lo` is high for one clock. Right after that, `fetch_hi` is high for max(1,EPER/4) clocks, but only if option bit 7 is set and the mode is 1 or 3.
- R10: `acc_ready` is high for exactly one clock, in the last phase of the access's final E cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, EPER clocks per E cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode (0 single, 1 expanded, 2 boot, 3 test) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register page offset of the write |
| reg_wdata | input | 8 | Register write data |
| opt_q | output | 8 | Current option register value |
| rom_low | input | 1 | ROM-placement flag selecting the stretch window |
| acc_valid | input | 1 | Core access request valid |
| acc_ready | output | 1 | Access completes at this edge |
| acc_addr | input | 16 | Access address |
| acc_rnw | input | 1 | 1 read, 0 write |
| fetch_req | input | 1 | Load-instruction strobe request from core |
| fetch_lo | output | 1 | Strobe pin pull-low enable |
| fetch_hi | output | 1 | Strobe pin active-high drive enable |
| e_clk | output | 1 | External E clock |
| ext_en | output | 1 | External bus cycle enable |
| data_oe | output | 1 | External data bus drive enable |
| core_wait | output | 1 | Core hold during the stretch cycle |
| itick | output | 16 | Free-running internal tick count |

## Verification
On every cycle the assertions check these rules: E is low while the core waits, the internal tick steps by one, single-chip and boot modes stay off the bus, the ready pulse lasts one clock, the high strobe drive follows a low pulse, the locked visibility bit holds, and the unused bits stay zero. Only the bench scenarios can show that the address windows, the ROM-placement flag and the mode decode choose the right accesses to go off-chip and to stretch. They also show that a stretched access takes exactly one more E cycle than a plain one, and that the register reset value follows the mode.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_EXPAND = 2'd1,
    MODE_BOOT   = 2'd2,
    MODE_TEST   = 2'd3
  } opmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XTRA = 2'd1,
    SQ_MAIN = 2'd2
  } seq_e;

  localparam int OB_DRVHI  = 7;
  localparam int OB_ODRAIN = 6;
  localparam int OB_STRCH  = 5;
  localparam int OB_VIS    = 4;
  localparam int OB_LSBF   = 3;
  localparam int OB_RATE   = 2;

  function automatic logic bus_mode(input logic [1:0] m);
    return (m == MODE_EXPAND) || (m == MODE_TEST);
  endfunction
endpackage

// File: rtl/xbus_opt_reg.sv
module xbus_opt_reg
  import xbus_pkg::*;
#(
  parameter int          OFS_W = 6,
  parameter logic [5:0]  OPT_OFS = 6'h38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             wr,
  input  logic [OFS_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       q,
  output logic             locked
);
  localparam logic [7:0] FREE_MASK = 8'b1110_1100;

  logic hit;
  logic test_m;
  assign hit    = wr && (addr == OFS_W'(OPT_OFS));
  assign test_m = (mode == MODE_TEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 8'h00;
      q[OB_VIS] <= test_m;
      locked <= 1'b0;
    end else if (hit) begin
      q <= (q & ~FREE_MASK) | (wdata & FREE_MASK);
      if (!locked || test_m) q[OB_VIS] <= wdata[OB_VIS];
      if (!test_m) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] RAM_BASE  = 16'h0000,
  parameter int          RAM_SIZE  = 1024,
  parameter logic [15:0] REGS_BASE = 16'h1000,
  parameter int          REGS_SIZE = 64
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          rnw,
  input  logic          rom_low,
  input  logic          strch_en,
  input  logic          vis_en,
  output logic          offchip,
  output logic          stretch,
  output logic          vis_show
);
  localparam int NREG = 2;
  localparam int BW   = AW + 1;

  logic [NREG-1:0] in_reg;
  logic [AW-1:0]   base [NREG];
  logic [BW-1:0]   size [NREG];

  assign base[0] = AW'(RAM_BASE);
  assign size[0] = BW'(RAM_SIZE);
  assign base[1] = AW'(REGS_BASE);
  assign size[1] = BW'(REGS_SIZE);

  for (genvar i = 0; i < NREG; i++) begin : g_region
    logic [BW-1:0] lo;
    logic [BW-1:0] a;
    assign lo = {1'b0, base[i]};
    assign a  = {1'b0, addr};
    assign in_reg[i] = (a >= lo) && (a < lo + size[i]);
  end

  logic onchip;
  logic in_win;
  assign onchip   = |in_reg;
  assign offchip  = bus_mode(mode) && !onchip;
  assign in_win   = rom_low ? !addr[AW-1] : addr[AW-1];
  assign stretch  = offchip && strch_en && in_win;
  assign vis_show = bus_mode(mode) && onchip && rnw && vis_en;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int EPER   = 4,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              dec_off,
  input  logic              dec_str,
  input  logic              dec_vis,
  input  logic              rnw,
  output logic              acc_ready,
  output logic              e_clk,
  output logic              ext_en,
  output logic              data_oe,
  output logic              core_wait,
  output logic [TICK_W-1:0] itick
);
  localparam int PW = (EPER > 1) ? $clog2(EPER) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(EPER - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(EPER / 2);

  logic [PW-1:0] ph;
  logic          last;
  seq_e          st;
  logic          off_q, wr_q, vis_q;

  assign last = (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      itick <= '0;
    end else begin
      ph    <= last ? '0 : ph + 1'b1;
      itick <= itick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      off_q <= 1'b0;
      wr_q  <= 1'b0;
      vis_q <= 1'b0;
    end else if (last) begin
      unique case (st)
        SQ_IDLE: if (acc_valid) begin
          st    <= dec_str ? SQ_XTRA : SQ_MAIN;
          off_q <= dec_off;
          wr_q  <= !rnw;
          vis_q <= dec_vis;
        end
        SQ_XTRA: st <= SQ_MAIN;
        SQ_MAIN: st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign acc_ready = (st == SQ_MAIN) && last;
  assign core_wait = (st == SQ_XTRA);
  assign e_clk     = (st != SQ_XTRA) && (ph >= PH_HALF);
  assign ext_en    = (st != SQ_IDLE) && off_q;
  assign data_oe   = (st == SQ_MAIN) && ((off_q && wr_q) || vis_q);
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe #(
  parameter int HI_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic drive_en,
  output logic lo,
  output logic hi
);
  localparam int CW = $clog2(HI_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo  <= 1'b0;
      cnt <= '0;
    end else begin
      lo <= req;
      if (lo && drive_en)  cnt <= CW'(HI_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign hi = (cnt != '0);
endmodule

// File: rtl/xbus_stretch_ctl.sv
module xbus_stretch_ctl
  import xbus_pkg::*;
#(
  parameter int          EPER      = 4,
  parameter int          TICK_W    = 16,
  parameter int          AW        = 16,
  parameter int          OFS_W     = 6,
  parameter logic [5:0]  OPT_OFS   = 6'h38,
  parameter logic [15:0] RAM_BASE  = 16'h0000,
  parameter int          RAM_SIZE  = 1024,
  parameter logic [15:0] REGS_BASE = 16'h1000,
  parameter int          REGS_SIZE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        opt_q,
  input  logic              rom_low,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_rnw,
  input  logic              fetch_req,
  output logic              fetch_lo,
  output logic              fetch_hi,
  output logic              e_clk,
  output logic              ext_en,
  output logic              data_oe,
  output logic              core_wait,
  output logic [TICK_W-1:0] itick
);
  localparam int HI_CYC = (EPER / 4 > 0) ? EPER / 4 : 1;

  logic vis_locked;
  logic dec_off, dec_str, dec_vis;
  logic drv_hi_en;

  xbus_opt_reg #(.OFS_W(OFS_W), .OPT_OFS(OPT_OFS)) u_reg (
    .clk(clk), .rst(rst), .mode(mode), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .q(opt_q), .locked(vis_locked)
  );

  xbus_decode #(
    .AW(AW), .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
    .REGS_BASE(REGS_BASE), .REGS_SIZE(REGS_SIZE)
  ) u_dec (
    .mode(mode), .addr(acc_addr), .rnw(acc_rnw), .rom_low(rom_low),
    .strch_en(opt_q[OB_STRCH]), .vis_en(opt_q[OB_VIS]),
    .offchip(dec_off), .stretch(dec_str), .vis_show(dec_vis)
  );

  xbus_seq #(.EPER(EPER), .TICK_W(TICK_W)) u_seq (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .dec_off(dec_off),
    .dec_str(dec_str), .dec_vis(dec_vis), .rnw(acc_rnw),
    .acc_ready(acc_ready), .e_clk(e_clk), .ext_en(ext_en),
    .data_oe(data_oe), .core_wait(core_wait), .itick(itick)
  );

  assign drv_hi_en = opt_q[OB_DRVHI] && bus_mode(mode);

  xbus_strobe #(.HI_CYC(HI_CYC)) u_stb (
    .clk(clk), .rst(rst), .req(fetch_req), .drive_en(drv_hi_en),
    .lo(fetch_lo), .hi(fetch_hi)
  );
endmodule

// File: rtl/xbus_stretch_chk.sv
module xbus_stretch_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [7:0]    opt_q,
  input logic          vis_locked,
  input logic          acc_ready,
  input logic          fetch_lo,
  input logic          fetch_hi,
  input logic          e_clk,
  input logic          ext_en,
  input logic          core_wait,
  input logic [TW-1:0] itick
);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    opt_q[1:0] == 2'b00);

  assert_vis_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (vis_locked && mode != 2'd3) |=> $stable(opt_q[4]));

  assert_no_bus_single_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 || mode == 2'd2) |-> !ext_en);

  assert_wait_e_low_R6: assert property (@(posedge clk) disable iff (rst)
    core_wait |-> (!e_clk && ext_en));

  assert_wait_then_main_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_wait) |-> ext_en);

  assert_tick_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> itick == TW'($past(itick) + 1'b1));

  assert_hi_after_lo_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_hi) |-> $past(fetch_lo));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    acc_ready |=> !acc_ready);
endmodule

bind xbus_stretch_ctl xbus_stretch_chk #(.TW(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .opt_q(opt_q), .vis_locked(vis_locked),
  .acc_ready(acc_ready), .fetch_lo(fetch_lo), .fetch_hi(fetch_hi),
  .e_clk(e_clk), .ext_en(ext_en), .core_wait(core_wait), .itick(itick)
);

// File: tb/sim_xbus_stretch_ctl.sv
`timescale 1ns/1ps
module sim_xbus_stretch_ctl;
  localparam int EPER = 4;
  localparam int NV   = 18;

  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  mode = 2'd1;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  opt_q;
  logic        rom_low = 0;
  logic        acc_valid = 0;
  logic        acc_ready;
  logic [15:0] acc_addr = '0;
  logic        acc_rnw = 1;
  logic        fetch_req = 0;
  logic        fetch_lo, fetch_hi, e_clk, ext_en, data_oe, core_wait;
  logic [15:0] itick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xbus_stretch_ctl #(.EPER(EPER)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .opt_q(opt_q), .rom_low(rom_low),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_rnw(acc_rnw), .fetch_req(fetch_req), .fetch_lo(fetch_lo),
    .fetch_hi(fetch_hi), .e_clk(e_clk), .ext_en(ext_en), .data_oe(data_oe),
    .core_wait(core_wait), .itick(itick)
  );

  // {mode, rom_low, stretch, vis, rnw, addr, exp_ext, exp_stretch, exp_doe}
  localparam logic [24:0] VEC [NV] = '{
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h4000,1'b1,1'b1,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b0,16'h9000,1'b1,1'b0,1'b1},
    {2'd1,1'b0,1'b1,1'b0,1'b1,16'h9000,1'b1,1'b1,1'b0},
    {2'd1,1'b0,1'b1,1'b0,1'b0,16'h4000,1'b1,1'b0,1'b1},
    {2'd1,1'b1,1'b0,1'b0,1'b1,16'h4000,1'b1,1'b0,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h0100,1'b0,1'b0,1'b0},
    {2'd1,1'b1,1'b1,1'b1,1'b1,16'h1020,1'b0,1'b0,1'b1},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h1020,1'b0,1'b0,1'b0},
    {2'd0,1'b1,1'b1,1'b1,1'b0,16'h4000,1'b0,1'b0,1'b0},
    {2'd2,1'b0,1'b1,1'b1,1'b1,16'h9000,1'b0,1'b0,1'b0},
    {2'd3,1'b1,1'b1,1'b1,1'b0,16'h2000,1'b1,1'b1,1'b1},
    {2'd3,1'b1,1'b0,1'b1,1'b1,16'h0200,1'b0,1'b0,1'b1},
    {2'd1,1'b1,1'b1,1'b0,1'b0,16'h103F,1'b0,1'b0,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b0,16'h1040,1'b1,1'b1,1'b1},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h7FFF,1'b1,1'b1,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h8000,1'b1,1'b0,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h03FF,1'b0,1'b0,1'b0},
    {2'd1,1'b1,1'b1,1'b0,1'b1,16'h0400,1'b1,1'b1,1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mode = m; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic access(input logic [15:0] a, input logic rnw,
                        output int n_ext, output int n_wait, output int doe,
                        output int e_viol, output int tick_ok);
    int n;
    logic [15:0] t0, t1;
    n = 0; n_ext = 0; n_wait = 0; doe = 0; e_viol = 0;
    t0 = '0; t1 = '0;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_rnw = rnw;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) t0 = itick;
      t1 = itick;
      if (ext_en) n_ext++;
      if (core_wait) n_wait++;
      if (data_oe) doe = 1;
      if (core_wait && e_clk) e_viol++;
    end while (!acc_ready && n < 100);
    tick_ok = (16'(t1 - t0) == 16'(n - 1)) ? 1 : 0;
    @(posedge clk);
    #1 acc_valid = 0;
    @(negedge clk);
    chk("R10 ready one clock", int'(acc_ready), 0);
  endtask

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ne, nw, od, ev, tk;
    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      do_reset(v[24:23]);
      rom_low = v[22];
      wreg(6'h38, {2'b00, v[21], v[20], 4'b0000});
      access(v[18:3], v[19], ne, nw, od, ev, tk);
      chk("R4 R6 ext_en clocks", ne, v[2] ? (v[1] ? 2*EPER : EPER) : 0);
      chk("R5 R6 wait clocks", nw, v[1] ? EPER : 0);
      chk("R8 data_oe", od, int'(v[0]));
      chk("R6 e low in wait", ev, 0);
      chk("R7 tick steady", tk, 1);
    end

    // R1 reset values
    do_reset(2'd1);
    @(negedge clk); chk("R1 reset expanded", int'(opt_q), 8'h00);
    do_reset(2'd3);
    @(negedge clk); chk("R1 reset test", int'(opt_q), 8'h10);
    do_reset(2'd0);
    @(negedge clk); chk("R1 reset single", int'(opt_q), 8'h00);

    // R2 write/offset decode, R3 write-once
    do_reset(2'd1);
    wreg(6'h37, 8'hFF);
    @(negedge clk); chk("R2 other offset ignored", int'(opt_q), 8'h00);
    wreg(6'h38, 8'hFF);
    @(negedge clk); chk("R2 write low bits zero", int'(opt_q), 8'hFC);
    wreg(6'h38, 8'h00);
    @(negedge clk); chk("R3 vis locked others clear", int'(opt_q), 8'h10);
    wreg(6'h38, 8'hEC);
    @(negedge clk); chk("R3 others still writable", int'(opt_q), 8'hFC);
    do_reset(2'd3);
    wreg(6'h38, 8'h00);
    @(negedge clk); chk("R3 test first write", int'(opt_q), 8'h00);
    wreg(6'h38, 8'h10);
    @(negedge clk); chk("R3 test rewrite", int'(opt_q), 8'h10);

    // R9 strobe shaping
    do_reset(2'd1);
    wreg(6'h38, 8'h80);
    @(negedge clk); fetch_req = 1;
    @(negedge clk); fetch_req = 0;
    chk("R9 lo pulse", int'(fetch_lo), 1);
    chk("R9 hi not yet", int'(fetch_hi), 0);
    @(negedge clk);
    chk("R9 lo ends", int'(fetch_lo), 0);
    chk("R9 hi drive", int'(fetch_hi), 1);
    @(negedge clk);
    chk("R9 hi ends", int'(fetch_hi), 0);
    wreg(6'h38, 8'h00);
    @(negedge clk); fetch_req = 1;
    @(negedge clk); fetch_req = 0;
    chk("R9 lo open drain", int'(fetch_lo), 1);
    @(negedge clk);
    chk("R9 no hi when clear", int'(fetch_hi), 0);
    do_reset(2'd0);
    wreg(6'h38, 8'h80);
    @(negedge clk); fetch_req = 1;
    @(negedge clk); fetch_req = 0;
    chk("R9 single lo", int'(fetch_lo), 1);
    @(negedge clk);
    chk("R9 single no hi", int'(fetch_hi), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule